// File: doc/BRIEF.md
# Performance Monitoring Counter Unit

This block watches a processor core without slowing it down. It has one free-running cycle counter and six event counters, and every counter is 32 bits wide. Each event counter gets an event code that software picks. Every cycle the block looks up each counter's event code against a vector of one-cycle event pulses from the core and cache logic. If the chosen pulse is high and counting is enabled, the counter steps by one. The block only samples these pulses and never drives anything back into the core, so counting can never stall it.

Software reaches the block through a simple register port. A write takes effect at the clock edge. A read is combinational from the address. Through this port, software can do the following:
- turn counting on and off, for the whole unit and for each counter;
- load any counter with a value;
- clear all event counters, or the cycle counter, with a single command bit;
- choose which event each counter tracks.

When a counter rolls over from all-ones to zero, a sticky overflow flag is set for that counter. The interrupt request is the OR of every flag whose mask bit is set.

Top module: `perfmon_unit`

## Requirements
- R1: After reset, every counter, enable bit, mask bit, status bit and event code reads as zero, and `irq` is low.
- R2: The cycle counter (read at address 0x04) adds one at each clock edge while the global enable (bit 0 of address 0x00) and its own enable (bit 6 of address 0x01) are both set. Otherwise it holds its value.
- R3: Event counter i (read at 0x08+i, i = 0..5) adds one for each cycle in which all of these hold: its selected event input is high, the global enable is set, and its enable bit (bit i of 0x01) is set. Otherwise it holds its value.
- R4: The event code of counter i sits in bits 7:0 at address 0x10+i. Code 0x50 selects `ev_in[0]`, the coherent line-fill miss pulse. Code 0x51 selects `ev_in[1]`, the coherent line-fill hit pulse. Codes 0x02 to 0x07 select `ev_in[2]` to `ev_in[7]`.
- R5: A counter whose event code is any other value never counts.
- R6: When a counter rolls over from 0xFFFFFFFF to 0, its sticky status bit is set at the same edge. The status register is at address 0x03, with bit i for event counter i and bit 6 for the cycle counter.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it as it is. If a clear and a new overflow of the same bit fall in the same cycle, the bit ends up set.
- R8: `irq` is high exactly when some status bit is set and its mask bit is also set. The mask is at address 0x02 and uses the same bit layout as the status register.
- R9: Writing address 0x00 with bit 1 set zeroes all event counters at that edge. Writing it with bit 2 set zeroes the cycle counter at that edge. Neither bit is stored, and reading 0x00 returns only the global enable.
- R10: A write to a counter's address loads that value, and the load takes priority over counting in the same cycle. Unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ev_in | input | 8 | One-cycle event pulses from the core and caches |
| irq | output | 1 | Overflow interrupt request |

## Verification
The checker runs on every cycle and covers these properties:
- each counter steps by exactly one when its increment is qualified, and holds its value when it is not;
- a counter that rolls over sets its status bit at the next edge;
- a status bit stays set until a write clears it;
- a clear command leaves every event counter at zero;
- the interrupt line is never raised while no status bit is set.

Some behaviour cannot be shown by these per-cycle properties and needs the bench's scenarios:
- which event input each code selects, and that unsupported codes never count;
- that the interrupt mask actually gates the interrupt line;
- that an overflow arriving in the same cycle as a clear of that status bit wins;
- that the clear bits are not stored.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] A_CNTEN = 5'h01;
  localparam logic [ADDR_W-1:0] A_IRQEN = 5'h02;
  localparam logic [ADDR_W-1:0] A_OVF   = 5'h03;
  localparam logic [ADDR_W-1:0] A_CYC   = 5'h04;
  localparam logic [ADDR_W-1:0] A_EVCNT = 5'h08;
  localparam logic [ADDR_W-1:0] A_EVSEL = 5'h10;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_EVRST = 1;
  localparam int CTRL_CYRST = 2;

  localparam logic [7:0] EV_LF_MISS = 8'h50;
  localparam logic [7:0] EV_LF_HIT  = 8'h51;
endpackage

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic         clr,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + {{(W-1){1'b0}}, 1'b1};
  endfunction

  // Roll-over only counts when the increment is not overridden.
  assign wrap = inc && !load && !clr && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= bump(cnt);
  end
endmodule

// File: rtl/pm_event_mux.sv
module pm_event_mux #(
  parameter int NUM_IN = 8,
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] code,
  input  logic [NUM_IN-1:0] ev_in,
  output logic              hit
);
  localparam int IDX_W = $clog2(NUM_IN);

  // Returns {valid, index} for an event code.
  function automatic logic [IDX_W:0] lookup(input logic [CODE_W-1:0] c);
    if (int'(c) == 'h50) return {1'b1, IDX_W'(0)};
    if (int'(c) == 'h51) return {1'b1, IDX_W'(1)};
    if (int'(c) >= 2 && int'(c) < NUM_IN) return {1'b1, c[IDX_W-1:0]};
    return '0;
  endfunction

  logic [IDX_W:0] sel;
  assign sel = lookup(code);
  assign hit = sel[IDX_W] && ev_in[sel[IDX_W-1:0]];
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter int NUM_CNT   = 6,
  parameter int CNT_W     = 32,
  parameter int NUM_EV_IN = 8,
  parameter int CODE_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [CNT_W-1:0]     reg_wdata,
  output logic [CNT_W-1:0]     reg_rdata,
  input  logic [NUM_EV_IN-1:0] ev_in,
  output logic                 irq
);
  localparam int NST     = NUM_CNT + 1;
  localparam int CYC_BIT = NUM_CNT;

  logic                          glob_en;
  logic [NST-1:0]                cnt_en;
  logic [NST-1:0]                irq_en;
  logic [NST-1:0]                ovf_q;
  logic [CODE_W-1:0]             ev_sel [NUM_CNT];

  // Named internal events, brought out for the checker.
  logic                          wr_ctrl;
  logic                          ev_clr, cyc_clr;
  logic                          cyc_inc, cyc_load, cyc_wrap;
  logic [NUM_CNT-1:0]            ev_hit, ev_inc, ev_load, ev_wrap;
  logic [NUM_CNT-1:0][CNT_W-1:0] ev_cnt;
  logic [CNT_W-1:0]              cyc_cnt;
  logic [NST-1:0]                ovf_wc, ovf_set;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign ev_clr   = wr_ctrl && reg_wdata[CTRL_EVRST];
  assign cyc_clr  = wr_ctrl && reg_wdata[CTRL_CYRST];
  assign cyc_load = reg_wr && (reg_addr == A_CYC);
  assign cyc_inc  = glob_en && cnt_en[CYC_BIT];

  pm_counter #(.W(CNT_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .inc(cyc_inc), .load(cyc_load), .clr(cyc_clr),
    .load_val(reg_wdata), .cnt(cyc_cnt), .wrap(cyc_wrap)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_ev
    pm_event_mux #(.NUM_IN(NUM_EV_IN), .CODE_W(CODE_W)) u_mux (
      .code(ev_sel[i]), .ev_in(ev_in), .hit(ev_hit[i])
    );
    assign ev_inc[i]  = glob_en && cnt_en[i] && ev_hit[i];
    assign ev_load[i] = reg_wr && (reg_addr == A_EVCNT + ADDR_W'(i));
    pm_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(ev_inc[i]), .load(ev_load[i]), .clr(ev_clr),
      .load_val(reg_wdata), .cnt(ev_cnt[i]), .wrap(ev_wrap[i])
    );
  end

  assign ovf_set = {cyc_wrap, ev_wrap};
  assign ovf_wc  = (reg_wr && reg_addr == A_OVF) ? reg_wdata[NST-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      cnt_en  <= '0;
      irq_en  <= '0;
      ovf_q   <= '0;
      for (int i = 0; i < NUM_CNT; i++) ev_sel[i] <= '0;
    end else begin
      ovf_q <= (ovf_q & ~ovf_wc) | ovf_set;
      if (wr_ctrl) glob_en <= reg_wdata[CTRL_EN];
      if (reg_wr && reg_addr == A_CNTEN) cnt_en <= reg_wdata[NST-1:0];
      if (reg_wr && reg_addr == A_IRQEN) irq_en <= reg_wdata[NST-1:0];
      for (int i = 0; i < NUM_CNT; i++)
        if (reg_wr && reg_addr == A_EVSEL + ADDR_W'(i)) ev_sel[i] <= reg_wdata[CODE_W-1:0];
    end
  end

  assign irq = |(ovf_q & irq_en);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[CTRL_EN] = glob_en;
      A_CNTEN: reg_rdata[NST-1:0] = cnt_en;
      A_IRQEN: reg_rdata[NST-1:0] = irq_en;
      A_OVF:   reg_rdata[NST-1:0] = ovf_q;
      A_CYC:   reg_rdata = cyc_cnt;
      default: ;
    endcase
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr == A_EVCNT + ADDR_W'(i)) reg_rdata = ev_cnt[i];
      if (reg_addr == A_EVSEL + ADDR_W'(i)) reg_rdata[CODE_W-1:0] = ev_sel[i];
    end
  end
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int NUM_CNT = 6,
  parameter int CNT_W   = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CNT-1:0][CNT_W-1:0] ev_cnt,
  input logic [NUM_CNT-1:0]            ev_inc,
  input logic [NUM_CNT-1:0]            ev_load,
  input logic [NUM_CNT-1:0]            ev_wrap,
  input logic                          ev_clr,
  input logic [CNT_W-1:0]              cyc_cnt,
  input logic                          cyc_inc,
  input logic                          cyc_load,
  input logic                          cyc_clr,
  input logic                          cyc_wrap,
  input logic [NUM_CNT:0]              ovf_q,
  input logic [NUM_CNT:0]              ovf_wc,
  input logic                          irq
);
  assert_cyc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_inc && !cyc_load && !cyc_clr |=> cyc_cnt == $past(cyc_cnt) + 1'b1);
  assert_cyc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_inc && !cyc_load && !cyc_clr |=> $stable(cyc_cnt));
  assert_cyc_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wrap |=> ovf_q[NUM_CNT]);
  assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ovf_q));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    assert_ev_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_inc[i] && !ev_load[i] && !ev_clr |=> ev_cnt[i] == $past(ev_cnt[i]) + 1'b1);
    assert_ev_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_inc[i] && !ev_load[i] && !ev_clr |=> $stable(ev_cnt[i]));
    assert_ev_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_wrap[i] |=> ovf_q[i]);
    assert_ev_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_clr |=> ev_cnt[i] == '0);
  end

  for (genvar b = 0; b <= NUM_CNT; b++) begin : g_sticky
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q[b] && !ovf_wc[b] |=> ovf_q[b]);
  end
endmodule

bind perfmon_unit pm_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_cnt(ev_cnt), .ev_inc(ev_inc), .ev_load(ev_load),
  .ev_wrap(ev_wrap), .ev_clr(ev_clr), .cyc_cnt(cyc_cnt), .cyc_inc(cyc_inc),
  .cyc_load(cyc_load), .cyc_clr(cyc_clr), .cyc_wrap(cyc_wrap), .ovf_q(ovf_q),
  .ovf_wc(ovf_wc), .irq(irq)
);

// File: tb/perfmon_unit_test.sv
`timescale 1ns/1ps
module perfmon_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  ev_in = '0;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  perfmon_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_in(ev_in), .irq(irq)
  );

  always #2 clk = ~clk;

  // Behavioural reference model
  logic [31:0] m_cnt [6];
  logic [31:0] m_cyc = '0;
  logic        m_en = 1'b0;
  logic [6:0]  m_cnten = '0, m_irqen = '0, m_ovf = '0;
  logic [7:0]  m_sel [6];

  initial for (int i = 0; i < 6; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end

  function automatic int ev_index(logic [7:0] c);
    if (c == 8'h50) return 0;
    if (c == 8'h51) return 1;
    if (c >= 8'h02 && c <= 8'h07) return int'(c);
    return -1;
  endfunction

  function automatic logic [31:0] model_read(logic [4:0] a);
    if (a == 5'h00) return {31'd0, m_en};
    if (a == 5'h01) return {25'd0, m_cnten};
    if (a == 5'h02) return {25'd0, m_irqen};
    if (a == 5'h03) return {25'd0, m_ovf};
    if (a == 5'h04) return m_cyc;
    if (a >= 5'h08 && a <= 5'h0D) return m_cnt[a - 5'h08];
    if (a >= 5'h10 && a <= 5'h15) return {24'd0, m_sel[a - 5'h10]};
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = '0; m_en = 0; m_cnten = '0; m_irqen = '0; m_ovf = '0;
      for (int i = 0; i < 6; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end
    end else begin
      logic [6:0] setm, clrm;
      bit w0;
      setm = '0;
      clrm = (reg_wr && reg_addr == 5'h03) ? reg_wdata[6:0] : 7'd0;
      w0 = reg_wr && reg_addr == 5'h00;
      for (int i = 0; i < 6; i++) begin
        int k;
        k = ev_index(m_sel[i]);
        if (w0 && reg_wdata[1]) m_cnt[i] = '0;
        else if (reg_wr && reg_addr == 5'h08 + 5'(i)) m_cnt[i] = reg_wdata;
        else if (m_en && m_cnten[i] && k >= 0 && ev_in[k]) begin
          if (m_cnt[i] == 32'hFFFF_FFFF) setm[i] = 1'b1;
          m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (w0 && reg_wdata[2]) m_cyc = '0;
      else if (reg_wr && reg_addr == 5'h04) m_cyc = reg_wdata;
      else if (m_en && m_cnten[6]) begin
        if (m_cyc == 32'hFFFF_FFFF) setm[6] = 1'b1;
        m_cyc = m_cyc + 1;
      end
      m_ovf = (m_ovf & ~clrm) | setm;
      if (w0) m_en = reg_wdata[0];
      if (reg_wr && reg_addr == 5'h01) m_cnten = reg_wdata[6:0];
      if (reg_wr && reg_addr == 5'h02) m_irqen = reg_wdata[6:0];
      for (int i = 0; i < 6; i++)
        if (reg_wr && reg_addr == 5'h10 + 5'(i)) m_sel[i] = reg_wdata[7:0];
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock; per-cycle comparison against the model at the following low phase.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      check("R8 irq", {31'd0, irq}, {31'd0, |(m_ovf & m_irqen)});
      check("R10 readback", reg_rdata, model_read(reg_addr));
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed, held;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 32; a++) rd_chk("R1 reset", 5'(a), 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // Setup, global enable still off
    wr(5'h01, 32'h7F);
    wr(5'h10, 32'h50); wr(5'h11, 32'h51); wr(5'h12, 32'h03);
    wr(5'h13, 32'h07); wr(5'h14, 32'h99); wr(5'h15, 32'h00);
    ev_in = 8'hFF; step(); step(); ev_in = 8'h00;
    rd_chk("R2 hold while globally off", 5'h04, 32'd0);
    rd_chk("R3 hold while globally off", 5'h08, 32'd0);

    // R3 R4 varied event patterns
    wr(5'h00, 32'h1);
    for (int n = 0; n < 60; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      ev_in = seed[23:16];
      step();
    end
    ev_in = 8'h00; step();
    for (int i = 0; i < 4; i++) rd_chk("R3 R4 event count", 5'h08 + 5'(i), m_cnt[i]);
    rd_chk("R5 unsupported 0x99", 5'h0C, 32'd0);
    rd_chk("R5 unsupported 0x00", 5'h0D, 32'd0);
    rd_chk("R2 cycle count", 5'h04, m_cyc);

    // R4 literal: exactly 3 pulses on line-fill miss input
    wr(5'h08, 32'd0);
    for (int n = 0; n < 3; n++) begin ev_in = 8'h01; step(); ev_in = 8'h00; step(); end
    rd_chk("R4 code 0x50 counts ev_in[0]", 5'h08, 32'd3);

    // R3 per-counter enable off for counter 2
    wr(5'h01, 32'h7B);
    rd(5'h0A, held);
    ev_in = 8'h08; step(); step(); ev_in = 8'h00;
    rd_chk("R3 disabled counter holds", 5'h0A, held);

    // R6 R8 R10 overflow of counter 1 with mask
    wr(5'h02, 32'h02);
    wr(5'h09, 32'hFFFF_FFFE);
    rd_chk("R10 load", 5'h09, 32'hFFFF_FFFE);
    ev_in = 8'h02; step(); step(); ev_in = 8'h00;
    rd_chk("R6 wrapped to zero", 5'h09, 32'd0);
    rd_chk("R6 status bit", 5'h03, 32'h02);
    check("R8 irq raised", {31'd0, irq}, 32'd1);

    // R7 write-one-to-clear
    wr(5'h03, 32'h00);
    rd_chk("R7 zero write keeps", 5'h03, 32'h02);
    wr(5'h03, 32'h02);
    rd_chk("R7 cleared", 5'h03, 32'h00);
    check("R8 irq dropped", {31'd0, irq}, 32'd0);

    // R7 set wins over clear in the same cycle
    wr(5'h08, 32'hFFFF_FFFF);
    ev_in = 8'h01; wr(5'h03, 32'h01); ev_in = 8'h00;
    rd_chk("R7 set wins", 5'h03, 32'h01);
    wr(5'h03, 32'h01);

    // R6 R8 cycle counter overflow, masked then unmasked
    wr(5'h04, 32'hFFFF_FFFD);
    step(); step(); step();
    rd_chk("R6 cycle status", 5'h03, 32'h40);
    check("R8 masked", {31'd0, irq}, 32'd0);
    wr(5'h02, 32'h40);
    check("R8 unmasked", {31'd0, irq}, 32'd1);

    // R9 reset command bits
    ev_in = 8'h00;
    wr(5'h00, 32'h3);
    for (int i = 0; i < 6; i++) rd_chk("R9 event counters zeroed", 5'h08 + 5'(i), 32'd0);
    rd_chk("R9 bits not stored", 5'h00, 32'd1);
    wr(5'h00, 32'h5);
    rd_chk("R9 cycle zeroed", 5'h04, 32'd0);
    rd_chk("R10 unused address", 5'h1F, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule